// File: doc/BRIEF.md
# Time-Shared Zero-Delay LMS Adaptive FIR Filter

This block is an adaptive FIR filter with a fixed number of taps. Each accepted sample is first filtered with the current coefficients. The block then forms the error against the desired response and updates every coefficient from that same error before the next sample can enter. No error from an older sample is ever used, so the adaptation delay is zero.

Each tap owns exactly one multiplier, and that multiplier is used twice per sample. In the filtering cycle an operand multiplexer gives it the stored coefficient and the tap's sample. A product demultiplexer sends the result into the output summation. In the update cycle the same multiplier receives the registered, shift-scaled error and the tap's sample, and the product goes to the tap's coefficient accumulator instead.

A phase bit sequences this two-cycle pattern. It limits the filter to one new sample every two clocks. The step size is a power of two and is chosen by a right-shift amount. All arithmetic is two's complement fixed point with saturation, and the output is aligned by a fractional shift.

Top module: `zdlms_filter`

## Requirements
- R1: A synchronous reset clears the phase bit, the sample delay line, every coefficient, `y_o`, `e_o` and `out_vld_o` to zero. The first sample after reset therefore yields `y_o` = 0.
- R2: A sample is accepted only when `smp_vld_i` is high in a filtering cycle, which is any cycle that is not the update cycle immediately after an acceptance. A strobe that is high during the update cycle is ignored: it produces no result and changes no coefficient or delay-line entry. In an idle filtering cycle the phase stays put and `y_o` holds.
- R3: On acceptance, `y_o` equals sat(floor(sum over k of w_k·s_k / 2^FRAC)), with FRAC = 15. Here s_0 is the incoming `x_i` and s_k (k ≥ 1) is the sample accepted k acceptances earlier. The coefficients w_k are those in force before this sample's update.
- R4: `e_o` equals sat(`d_i` − `y_o`), computed with one extra bit before saturation.
- R5: In the update cycle each coefficient becomes sat(w_k + floor(g·s_k / 2^FRAC)), where g = floor(`e_o` / 2^`mu_sh_i`). The same s_k is used as in R3. The new coefficients are in force for the very next accepted sample.
- R6: `out_vld_o` is a one-cycle pulse that is high in the cycle after the update cycle, i.e. two clock edges after the accepting edge. `y_o` and `e_o` are valid during the pulse. With the strobe held high, one result appears every two clocks.
- R7: The step shift `mu_sh_i` takes every value from 0 to 15 as an arithmetic right shift of the error, so that negative errors round toward minus infinity. It is sampled in the accepting cycle.
- R8: Saturation limits `y_o`, `e_o` and every coefficient to the range −32768 to 32767. The output summation carries ceil(log2 TAPS) guard bits, so a sum beyond the 16-bit range clips instead of wrapping.
- R9: When the filter identifies a fixed 4-tap system driven by random input, the mean squared error over the last 64 samples is less than one eighth of the mean squared error over the first 64 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld_i | input | 1 | New sample strobe |
| x_i | input | 16 | Signed input sample |
| d_i | input | 16 | Signed desired response |
| mu_sh_i | input | 4 | Step size as a right-shift amount (0 to 15) |
| y_o | output | 16 | Filter output, saturated |
| e_o | output | 16 | Error d − y, saturated |
| out_vld_o | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is a strobe that arrives during the update cycle, while the shared multipliers are busy with the coefficient update. A correct design ignores it. A design that honoured it would corrupt both the delay line and the coefficients, yet no output would show anything wrong at that moment. To bring this about, the driver keeps the strobe high across the update edge and puts garbage values on the sample and desired inputs. The scoreboard then compares later results bit for bit against a model that never saw those values. Any stray shift or update therefore appears as a mismatch, and any extra result pulse appears as an unexpected item. Saturation is reached by driving full-scale samples with a zero shift until the coefficients grow large, first with positive samples and then with the most negative sample.

// File: rtl/zdlms_pkg.sv
package zdlms_pkg;
   typedef enum logic {
      PH_FILT = 1'b0,
      PH_UPD  = 1'b1
   } phase_t;
endpackage

// File: rtl/zdlms_tap.sv
module zdlms_tap
   import zdlms_pkg::*;
#(
   parameter int DW   = 16,
   parameter int FRAC = 15
) (
   input  logic                   clk,
   input  logic                   rst,
   input  phase_t                 phase,
   input  logic signed [DW-1:0]   smp_new,
   input  logic signed [DW-1:0]   smp_old,
   input  logic signed [DW-1:0]   err_scaled,
   output logic signed [2*DW-1:0] fir_prod
);
   localparam int    PW   = 2 * DW;
   localparam int    UW   = PW + 1;
   localparam longint WMAX = (longint'(1) <<< (DW - 1)) - 1;
   localparam longint WMIN = -(longint'(1) <<< (DW - 1));

   logic signed [DW-1:0] w_q;
   logic signed [DW-1:0] op_a;
   logic signed [DW-1:0] op_b;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] upd_prod;
   logic signed [UW-1:0] w_sum;

   // operand multiplexers: coefficient or scaled error, current or held sample
   always_comb begin
      op_a = (phase == PH_UPD) ? err_scaled : w_q;
      op_b = (phase == PH_UPD) ? smp_old    : smp_new;
      prod = op_a * op_b;
   end

   // product demultiplexer: summation path or coefficient path
   always_comb begin
      fir_prod = (phase == PH_FILT) ? prod : '0;
      upd_prod = (phase == PH_UPD)  ? prod : '0;
      w_sum    = UW'(w_q) + UW'(upd_prod >>> FRAC);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         w_q <= '0;
      end else if (phase == PH_UPD) begin
         if (w_sum > WMAX)       w_q <= DW'(WMAX);
         else if (w_sum < WMIN)  w_q <= DW'(WMIN);
         else                    w_q <= DW'(w_sum);
      end
   end
endmodule

// File: rtl/zdlms_sum.sv
module zdlms_sum #(
   parameter int N  = 4,
   parameter int PW = 32,
   parameter int OW = 34
) (
   input  logic signed [PW-1:0] terms [N],
   output logic signed [OW-1:0] total
);
   always_comb begin
      total = '0;
      for (int k = 0; k < N; k++) begin
         total = total + OW'(terms[k]);
      end
   end
endmodule

// File: rtl/zdlms_filter.sv
module zdlms_filter
   import zdlms_pkg::*;
#(
   parameter int TAPS = 4,
   parameter int DW   = 16,
   parameter int FRAC = 15,
   parameter int SHW  = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_vld_i,
   input  logic signed [DW-1:0] x_i,
   input  logic signed [DW-1:0] d_i,
   input  logic [SHW-1:0]       mu_sh_i,
   output logic signed [DW-1:0] y_o,
   output logic signed [DW-1:0] e_o,
   output logic                 out_vld_o
);
   localparam int     PW    = 2 * DW;
   localparam int     GUARD = $clog2(TAPS);
   localparam int     ACCW  = PW + GUARD;
   localparam longint SMAX  = (longint'(1) <<< (DW - 1)) - 1;
   localparam longint SMIN  = -(longint'(1) <<< (DW - 1));

   if (TAPS < 1)            begin : g_bad_taps  $error("TAPS must be at least 1");        end
   if (DW < 2 || DW > 31)   begin : g_bad_dw    $error("DW must lie in 2..31");           end
   if (FRAC >= PW)          begin : g_bad_frac  $error("FRAC must be below 2*DW");        end
   if (SHW < 1 || SHW > 5)  begin : g_bad_shw   $error("SHW must lie in 1..5");           end

   phase_t                ph_q;
   logic                  upd_phase;
   logic                  accept;
   logic signed [DW-1:0]  dl_q [TAPS];
   logic signed [PW-1:0]  terms [TAPS];
   logic signed [ACCW-1:0] acc;
   logic signed [ACCW-1:0] acc_sh;
   logic signed [DW-1:0]  y_sat;
   logic signed [DW:0]    e_wide;
   logic signed [DW-1:0]  e_sat;
   logic signed [DW-1:0]  se_next;
   logic signed [DW-1:0]  se_q;
   logic signed [DW-1:0]  y_q;
   logic signed [DW-1:0]  e_q;
   logic                  vld_q;

   assign upd_phase = (ph_q == PH_UPD);
   assign accept    = smp_vld_i && (ph_q == PH_FILT);

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      logic signed [DW-1:0] cur_smp;
      if (k == 0) begin : g_head
         assign cur_smp = x_i;
      end else begin : g_body
         assign cur_smp = dl_q[k-1];
      end
      zdlms_tap #(.DW(DW), .FRAC(FRAC)) tap_i (
         .clk        (clk),
         .rst        (rst),
         .phase      (ph_q),
         .smp_new    (cur_smp),
         .smp_old    (dl_q[k]),
         .err_scaled (se_q),
         .fir_prod   (terms[k])
      );
   end

   zdlms_sum #(.N(TAPS), .PW(PW), .OW(ACCW)) sum_i (
      .terms (terms),
      .total (acc)
   );

   always_comb begin
      acc_sh = acc >>> FRAC;
      if (acc_sh > SMAX)      y_sat = DW'(SMAX);
      else if (acc_sh < SMIN) y_sat = DW'(SMIN);
      else                    y_sat = DW'(acc_sh);
      e_wide = (DW+1)'(d_i) - (DW+1)'(y_sat);
      if (e_wide > SMAX)      e_sat = DW'(SMAX);
      else if (e_wide < SMIN) e_sat = DW'(SMIN);
      else                    e_sat = DW'(e_wide);
      se_next = e_sat >>> mu_sh_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= PH_FILT;
         y_q   <= '0;
         e_q   <= '0;
         se_q  <= '0;
         vld_q <= 1'b0;
         for (int k = 0; k < TAPS; k++) dl_q[k] <= '0;
      end else begin
         vld_q <= upd_phase;
         if (upd_phase) begin
            ph_q <= PH_FILT;
         end else if (accept) begin
            ph_q    <= PH_UPD;
            y_q     <= y_sat;
            e_q     <= e_sat;
            se_q    <= se_next;
            dl_q[0] <= x_i;
            for (int k = 1; k < TAPS; k++) dl_q[k] <= dl_q[k-1];
         end
      end
   end

   assign y_o       = y_q;
   assign e_o       = e_q;
   assign out_vld_o = vld_q;
endmodule

// File: rtl/zdlms_chk.sv
module zdlms_chk #(
   parameter int DW = 16
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 smp_vld_i,
   input logic signed [DW-1:0] d_i,
   input logic signed [DW-1:0] y_o,
   input logic signed [DW-1:0] e_o,
   input logic                 out_vld_o,
   input logic                 upd_phase
);
   localparam longint SMAX = (longint'(1) <<< (DW - 1)) - 1;
   localparam longint SMIN = -(longint'(1) <<< (DW - 1));

   logic signed [DW-1:0] d_cap;
   logic signed [DW:0]   diff;
   logic signed [DW-1:0] diff_sat;

   always_ff @(posedge clk) begin
      if (rst) d_cap <= '0;
      else if (smp_vld_i && !upd_phase) d_cap <= d_i;
   end

   always_comb begin
      diff = (DW+1)'(d_cap) - (DW+1)'(y_o);
      if (diff > SMAX)      diff_sat = DW'(SMAX);
      else if (diff < SMIN) diff_sat = DW'(SMIN);
      else                  diff_sat = DW'(diff);
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!out_vld_o && y_o == '0 && e_o == '0));

   p_upd_single_r2: assert property (@(posedge clk) disable iff (rst)
      upd_phase |=> !upd_phase);

   p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
      (!upd_phase && !smp_vld_i) |=> (!upd_phase && $stable(y_o)));

   p_err_match_r4: assert property (@(posedge clk) disable iff (rst)
      out_vld_o |-> (e_o == diff_sat));

   p_pulse_once_r6: assert property (@(posedge clk) disable iff (rst)
      out_vld_o |=> !out_vld_o);

   p_latency_r6: assert property (@(posedge clk) disable iff (rst)
      (smp_vld_i && !upd_phase) |=> ##1 out_vld_o);
endmodule

bind zdlms_filter zdlms_chk #(.DW(DW)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .smp_vld_i (smp_vld_i),
   .d_i       (d_i),
   .y_o       (y_o),
   .e_o       (e_o),
   .out_vld_o (out_vld_o),
   .upd_phase (upd_phase)
);

// File: tb/zdlms_filter_tb_top.sv
module zdlms_filter_tb_top;
   localparam int N = 4;

   typedef struct {
      longint y;
      longint e;
      string  tag;
   } item_t;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               smp_vld_i = 1'b0;
   logic signed [15:0] x_i = '0;
   logic signed [15:0] d_i = '0;
   logic [3:0]         mu_sh_i = '0;
   logic signed [15:0] y_o;
   logic signed [15:0] e_o;
   logic               out_vld_o;

   int     n_chk = 0;
   int     n_err = 0;
   int     n_out = 0;
   int     n_push = 0;
   item_t  exp_q [$];
   longint sq_log [$];
   longint wm [N];
   longint xm [N];
   longint hx [N];
   bit     prev_vld = 1'b0;
   bit     sat_hi = 1'b0;
   bit     sat_lo = 1'b0;

   zdlms_filter dut_i (
      .clk       (clk),
      .rst       (rst),
      .smp_vld_i (smp_vld_i),
      .x_i       (x_i),
      .d_i       (d_i),
      .mu_sh_i   (mu_sh_i),
      .y_o       (y_o),
      .e_o       (e_o),
      .out_vld_o (out_vld_o)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint sat16(input longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < N; k++) begin
         wm[k] = 0;
         xm[k] = 0;
      end
   endtask

   task automatic model_step(input longint x, input longint d, input int mu, input string tag);
      longint acc;
      longint y;
      longint e;
      longint g;
      item_t  it;
      for (int k = N - 1; k > 0; k--) xm[k] = xm[k-1];
      xm[0] = x;
      acc = 0;
      for (int k = 0; k < N; k++) acc += wm[k] * xm[k];
      y = sat16(acc >>> 15);
      e = sat16(d - y);
      g = e >>> mu;
      for (int k = 0; k < N; k++) wm[k] = sat16(wm[k] + ((g * xm[k]) >>> 15));
      it.y = y;
      it.e = e;
      it.tag = tag;
      exp_q.push_back(it);
      n_push++;
   endtask

   // drive one sample; when hold is set the strobe stays high with garbage over the update edge
   task automatic send(input longint x, input longint d, input int mu, input string tag, input bit hold);
      @(negedge clk);
      smp_vld_i = 1'b1;
      x_i = 16'(x);
      d_i = 16'(d);
      mu_sh_i = 4'(mu);
      model_step(x, d, mu, tag);
      @(posedge clk);
      @(negedge clk);
      if (hold) begin
         x_i = 16'h5a5a;
         d_i = 16'hc3c3;
         mu_sh_i = 4'd0;
      end else begin
         smp_vld_i = 1'b0;
      end
      @(posedge clk);
      #1 smp_vld_i = 1'b0;
   endtask

   function automatic longint rnd_smp();
      return longint'($urandom_range(0, 16383)) - 8192;
   endfunction

   function automatic longint plant(input longint x);
      longint acc;
      for (int k = N - 1; k > 0; k--) hx[k] = hx[k-1];
      hx[0] = x;
      acc = 8192 * hx[0] - 4096 * hx[1] + 2048 * hx[2] + 1024 * hx[3];
      return sat16(acc >>> 15);
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (out_vld_o && prev_vld) chk(1'b0, "R6 pulse wider than one cycle", 1, 0);
         if (out_vld_o) begin
            n_out++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 R6 unexpected result", longint'(y_o), 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               chk(longint'(y_o) == it.y, {it.tag, " y_o"}, longint'(y_o), it.y);
               chk(longint'(e_o) == it.e, "R4 e_o", longint'(e_o), it.e);
               if (it.tag == "R9 R3 R5") sq_log.push_back(it.e * it.e);
               if (it.tag == "R8 R3 R5") begin
                  if (y_o == 16'sd32767)  sat_hi = 1'b1;
                  if (y_o == -16'sd32768) sat_lo = 1'b1;
               end
            end
         end
         prev_vld = out_vld_o;
      end else begin
         prev_vld = 1'b0;
      end
   end

   initial begin
      #(20 * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      longint first_sum;
      longint last_sum;
      model_reset();
      for (int k = 0; k < N; k++) hx[k] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk(y_o == 0, "R1 reset y_o", longint'(y_o), 0);
      chk(e_o == 0, "R1 reset e_o", longint'(e_o), 0);
      chk(out_vld_o == 1'b0, "R1 reset out_vld_o", longint'(out_vld_o), 0);

      // R1: the first result after reset uses zero coefficients
      begin
         longint xs = rnd_smp();
         send(xs, plant(xs), 1, "R1 R3", 1'b0);
      end

      // R9: system identification, with R3 and R5 checked bit-exactly on every result
      for (int i = 0; i < 600; i++) begin
         longint xs = rnd_smp();
         send(xs, plant(xs), 1, "R9 R3 R5", 1'b0);
      end
      repeat (4) @(negedge clk);
      first_sum = 0;
      last_sum = 0;
      for (int i = 0; i < 64; i++) begin
         first_sum += sq_log[i];
         last_sum  += sq_log[sq_log.size() - 64 + i];
      end
      chk(last_sum * 8 < first_sum, "R9 error energy falls", last_sum, first_sum / 8);

      // R2: a strobe held over the update edge carries garbage that must be ignored
      for (int i = 0; i < 20; i++) begin
         longint xs = rnd_smp();
         send(xs, plant(xs), 1, "R2 R3", 1'b1);
      end
      // R6: idle gaps between samples
      for (int i = 0; i < 10; i++) begin
         longint xs = rnd_smp();
         send(xs, plant(xs), 2, "R6 R3", 1'b0);
         repeat (i % 3 + 1) @(negedge clk);
      end

      // R7: every shift amount with random data
      for (int mu = 0; mu < 16; mu++) begin
         for (int i = 0; i < 6; i++) begin
            send(rnd_smp(), longint'($urandom_range(0, 65535)) - 32768, mu, "R7 R3 R5", 1'b0);
         end
      end
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);

      // R8: saturation after a fresh reset
      @(negedge clk);
      rst = 1'b1;
      model_reset();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk(y_o == 0 && out_vld_o == 1'b0, "R1 second reset", longint'(y_o), 0);
      for (int i = 0; i < 12; i++) send(32767, 32767, 0, "R8 R3 R5", 1'b0);
      for (int i = 0; i < 12; i++) send(-32768, -32768, 0, "R8 R3 R5", 1'b0);
      repeat (4) @(negedge clk);
      chk(sat_hi, "R8 positive clip reached", longint'(sat_hi), 1);
      chk(sat_lo, "R8 negative clip reached", longint'(sat_lo), 1);
      chk(exp_q.size() == 0, "R6 queue empty at end", exp_q.size(), 0);
      chk(n_out == n_push, "R2 R6 result count", n_out, n_push);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule